// File: doc/BRIEF.md
# Timer Count-Enable Source Selector

This block turns the system clock into a single-cycle count-enable pulse for a timer. The pulse is never used as a clock. A 3-bit source code picks the rate. One code holds the timer still. One code enables it on every cycle. Four codes enable it at fixed binary fractions of the system clock. The last two codes enable it once for each transition, falling or rising, of an asynchronous external input pin.

All divided rates come from one shared free-running counter, so timers fed from the same prescaler stay in phase. A synchronous prescaler-clear input restarts that counter, which makes the next divided pulse arrive a full period later. The external pin goes through a synchronizer and then an edge detector. Every flop is clocked by the system clock.

Top module: `tmr_tick_gen`

## Requirements
- R1: With source code 0 (stop), `tick_o` stays low.
- R2: With source code 1 (full rate), `tick_o` is high on every cycle.
- R3: Codes 2, 3, 4 and 5 divide the system clock by 8, 64, 256 and 1024. A shared 10-bit counter starts at 0 after reset and adds one per cycle. `tick_o` is high in the cycle after the counter's low 3, 6, 8 or 10 bits (in that code order) were all ones. So after reset the first pulse for code 2 appears in the cycle that follows the eighth clock edge.
- R4: While `psc_clr_i` is high, no divided pulse is produced on the following cycle, and the counter is forced to 0. A code-2 pulse therefore arrives 8 cycles after the last cycle in which the clear was high.
- R5: Code 6 produces one pulse per high-to-low transition of `ext_pin_i`.
- R6: Code 7 produces one pulse per low-to-high transition of `ext_pin_i`.
- R7: Suppose clock edge k is the first edge to sample a new pin level. The matching pulse is then high from edge k+2 to edge k+3. A pin held at a level after one transition yields exactly one pulse.
- R8: `tick_o` is a registered single-cycle pulse. The code present at one clock edge decides the value of `tick_o` after that edge, so a change of code takes effect on the next cycle.
- R9: While `rst_ni` is low, `tick_o` is low, the counter is 0 and the synchronizer holds low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_sel_i | input | 3 | Count source code, 0 to 7 |
| psc_clr_i | input | 1 | Synchronous clear of the shared prescaler counter |
| ext_pin_i | input | 1 | Asynchronous external count input |
| tick_o | output | 1 | Single-cycle count-enable pulse |

## Verification
On every cycle the assertions tie each code to its source. Stop and full rate give a fixed output. Divided codes must pulse exactly when the shared counter's low bits roll over to zero, and never right after a clear. The two pin codes must follow the detector's previous-cycle falling or rising flag, and the two flags may never be high together. Only the bench scenarios show the absolute rates from reset, the three-edge pin latency, that one held transition yields exactly one pulse, and the rapid code hopping that exercises the next-cycle switching rule.

// File: rtl/tmr_tick_pkg.sv
package tmr_tick_pkg;

    localparam int unsigned SEL_W     = 3;
    localparam int unsigned TAP_COUNT = 4;

    typedef enum logic [SEL_W-1:0] {
        SRC_STOP     = 3'd0,
        SRC_FULL     = 3'd1,
        SRC_DIV8     = 3'd2,
        SRC_DIV64    = 3'd3,
        SRC_DIV256   = 3'd4,
        SRC_DIV1024  = 3'd5,
        SRC_PIN_FALL = 3'd6,
        SRC_PIN_RISE = 3'd7
    } src_sel_e;

    // Number of low counter bits that must all be ones for each tap.
    function automatic int unsigned tap_width(input int unsigned idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

    function automatic logic sel_is_div(input src_sel_e s);
        return (s == SRC_DIV8) || (s == SRC_DIV64) ||
               (s == SRC_DIV256) || (s == SRC_DIV1024);
    endfunction

    // Tap index for a divided code; 0 for other codes.
    function automatic int unsigned sel_tap(input src_sel_e s);
        case (s)
            SRC_DIV64:   return 1;
            SRC_DIV256:  return 2;
            SRC_DIV1024: return 3;
            default:     return 0;
        endcase
    endfunction

endpackage

// File: rtl/tmr_psc_div.sv
// Shared free-running prescaler counter with one rollover tap per divided rate.
module tmr_psc_div
    import tmr_tick_pkg::*;
#(
    parameter int unsigned CNT_W  = 10,
    parameter int unsigned N_TAPS = TAP_COUNT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              clr_i,
    output logic [N_TAPS-1:0] tap_o,
    output logic [CNT_W-1:0]  cnt_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } psc_state_t;

    psc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // A tap fires when its low bits are all ones; a clear suppresses it.
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        localparam int unsigned TW = tap_width(g);
        assign tap_o[g] = (&st_q.cnt[TW-1:0]) & ~clr_i;
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/tmr_pin_edge.sv
// Multi-flop synchronizer for the external pin, followed by an edge detector.
module tmr_pin_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);

    localparam int unsigned MSB = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_state_t;

    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], pin_i};
        st_d.prev = st_q.sync[MSB];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o =  st_q.sync[MSB] & ~st_q.prev;
    assign fall_o = ~st_q.sync[MSB] &  st_q.prev;

endmodule

// File: rtl/tmr_src_mux.sv
// Decodes the source code and registers the selected count-enable pulse.
module tmr_src_mux
    import tmr_tick_pkg::*;
#(
    parameter int unsigned N_TAPS = TAP_COUNT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic [N_TAPS-1:0] tap_i,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic              tick_o
);

    typedef struct packed {
        logic tick;
    } mux_state_t;

    mux_state_t st_d, st_q;
    src_sel_e   src;

    always_comb begin
        src  = src_sel_e'(sel_i);
        st_d = st_q;
        case (src)
            SRC_STOP:     st_d.tick = 1'b0;
            SRC_FULL:     st_d.tick = 1'b1;
            SRC_DIV8,
            SRC_DIV64,
            SRC_DIV256,
            SRC_DIV1024:  st_d.tick = tap_i[sel_tap(src)];
            SRC_PIN_FALL: st_d.tick = fall_i;
            SRC_PIN_RISE: st_d.tick = rise_i;
            default:      st_d.tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_tick_pkg::*;
#(
    parameter int unsigned CNT_W       = 10,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] src_sel_i,
    input  logic             psc_clr_i,
    input  logic             ext_pin_i,
    output logic             tick_o
);

    logic [TAP_COUNT-1:0] psc_tap;
    logic [CNT_W-1:0]     psc_cnt;
    logic                 pin_rise;
    logic                 pin_fall;

    tmr_psc_div #(
        .CNT_W  (CNT_W),
        .N_TAPS (TAP_COUNT)
    ) u_psc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (psc_clr_i),
        .tap_o  (psc_tap),
        .cnt_o  (psc_cnt)
    );

    tmr_pin_edge #(
        .STAGES (SYNC_STAGES)
    ) u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (ext_pin_i),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    tmr_src_mux #(
        .N_TAPS (TAP_COUNT)
    ) u_mux (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sel_i  (src_sel_i),
        .tap_i  (psc_tap),
        .rise_i (pin_rise),
        .fall_i (pin_fall),
        .tick_o (tick_o)
    );

endmodule

// File: rtl/tmr_tick_gen_chk.sv
module tmr_tick_gen_chk
    import tmr_tick_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [SEL_W-1:0] sel_i,
    input logic             clr_i,
    input logic             tick_i,
    input logic [CNT_W-1:0] cnt_i,
    input logic             rise_i,
    input logic             fall_i
);

    function automatic logic low_zero(input logic [CNT_W-1:0] c, input logic [SEL_W-1:0] s);
        int unsigned w;
        logic [CNT_W-1:0] m;
        w = tap_width(sel_tap(src_sel_e'(s)));
        m = CNT_W'((1 << w) - 1);
        return (c & m) == '0;
    endfunction

    p_stop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SRC_STOP) |=> !tick_i);

    p_full_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SRC_FULL) |=> tick_i);

    // R3: divided pulses line up with the counter's low bits rolling to zero.
    p_div_phase_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_is_div(src_sel_e'(sel_i)) && !clr_i) |=> (tick_i == low_zero(cnt_i, $past(sel_i))));

    p_clr_quiet_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && sel_is_div(src_sel_e'(sel_i))) |=> !tick_i);

    p_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SRC_PIN_FALL) |=> (tick_i == $past(fall_i)));

    p_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sel_i == SRC_PIN_RISE) |=> (tick_i == $past(rise_i)));

    // R7: the detector never reports both directions in one cycle.
    p_edge_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rise_i && fall_i));

endmodule

bind tmr_tick_gen tmr_tick_gen_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (src_sel_i),
    .clr_i  (psc_clr_i),
    .tick_i (tick_o),
    .cnt_i  (psc_cnt),
    .rise_i (pin_rise),
    .fall_i (pin_fall)
);

// File: tb/sim_tmr_tick_gen.sv
`timescale 1ns/1ps
module sim_tmr_tick_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] sel = 3'd0;
    logic       clr = 1'b0;
    logic       pin = 1'b0;
    logic       tick;

    int   vecs = 0;
    int   errs = 0;
    bit   done = 0;

    // Bench model state
    int   m_cnt = 0;
    bit   m_s1 = 0, m_s2 = 0, m_prev = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #2.5 clk = ~clk;

    tmr_tick_gen u0 (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .src_sel_i (sel),
        .psc_clr_i (clr),
        .ext_pin_i (pin),
        .tick_o    (tick)
    );

    function automatic string req_of(input int s);
        case (s)
            0: return "R1";
            1: return "R2";
            6: return "R5 R7";
            7: return "R6 R7";
            default: return "R3";
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        vecs++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: sel=%0d clr=%b actual=%b expected=%b", req, sel, clr, act, exp);
        end
    endtask

    // One clock: predict tick from current inputs and model, advance, compare.
    task automatic step(input string req);
        bit exp;
        int m;
        case (sel)
            3'd0: exp = 0;
            3'd1: exp = 1;
            3'd6: exp = !m_s2 && m_prev;
            3'd7: exp = m_s2 && !m_prev;
            default: begin
                m   = (sel == 3'd2) ? 7 : (sel == 3'd3) ? 63 : (sel == 3'd4) ? 255 : 1023;
                exp = !clr && ((m_cnt & m) == m);
            end
        endcase
        m_cnt  = clr ? 0 : (m_cnt + 1) % 1024;
        m_prev = m_s2;
        m_s2   = m_s1;
        m_s1   = pin;
        @(posedge clk);
        #1;
        check(req, tick, exp);
    endtask

    task automatic lfsr_adv();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int cnt_ticks;
        // R9: reset holds output low
        repeat (3) @(posedge clk);
        #1;
        check("R9", tick, 1'b0);
        sel = 3'd2;
        @(posedge clk);
        #1;
        check("R9", tick, 1'b0);
        sel = 3'd0;
        rst_n = 1'b1;

        // R3: first code-2 pulse after the eighth edge from reset
        sel = 3'd2;
        for (int c = 0; c < 16; c++) step("R3");

        // Sweep every code with busy pin activity and one clear pulse
        for (int s = 0; s < 8; s++) begin
            sel = 3'(s);
            for (int c = 0; c < 1100; c++) begin
                lfsr_adv();
                if (lfsr[1]) pin = lfsr[0];
                clr = (c == 500) || (c == 501);
                step(clr ? "R4" : req_of(s));
            end
            clr = 1'b0;
        end

        // R4: after clear, code-2 pulse exactly 8 cycles later
        sel = 3'd2;
        clr = 1'b1;
        step("R4");
        clr = 1'b0;
        cnt_ticks = 0;
        for (int c = 1; c <= 8; c++) begin
            step("R4");
            if (tick) cnt_ticks = c;
        end
        check("R4", cnt_ticks == 8, 1'b1);

        // R7: latency and single pulse per held transition
        sel = 3'd7;
        pin = 1'b0;
        for (int c = 0; c < 6; c++) step("R7");
        pin = 1'b1;
        cnt_ticks = 0;
        for (int c = 1; c <= 10; c++) begin
            step("R7");
            if (tick) begin
                cnt_ticks++;
                check("R7", c == 3, 1'b1);
            end
        end
        check("R7", cnt_ticks == 1, 1'b1);
        sel = 3'd6;
        pin = 1'b0;
        cnt_ticks = 0;
        for (int c = 1; c <= 10; c++) begin
            step("R5");
            if (tick) cnt_ticks++;
        end
        check("R5", cnt_ticks == 1, 1'b1);

        // R8: code hopping every cycle
        for (int c = 0; c < 600; c++) begin
            lfsr_adv();
            sel = lfsr[4:2];
            clr = lfsr[7] & lfsr[8] & lfsr[9];
            pin = lfsr[0];
            step("R8");
        end
        clr = 1'b0;

        finish_run();
    end

endmodule